// File: doc/BRIEF.md
# Stacked Frame Row Scanner with Interrupt Timing

This block sets the row timing for a passive matrix panel whose physical frame is always 64 rows tall. A programmable divider sets the length of one row. Each row starts with a one-cycle strobe, and the strobe comes together with the new physical and logical row indices. The logical frame height is chosen by a 2-bit code. When that height is less than 64, logical frames repeat down the panel until the physical frame is full. If the height does not divide 64, the last logical frame is cut off at the physical frame boundary.

Each logical frame raises two interrupts. They fire one row past its quarter point and one row past its three-quarter point. The request stays up until the processor acknowledges it. At the start of every row the block asks the row fetch engine to begin a DMA. For a row that raised an interrupt, that request is held back until the acknowledge arrives. The drive polarity flips at the start of every physical frame, so the panel sees an alternating drive. While the display is disabled, the block is parked: no strobes, no requests and no fetches.

Top module: `frame_scan_timer`

## Requirements
- R1: With divider value D, consecutive row strobes are exactly D+1 clock cycles apart. The strobe is high for one cycle, in the same cycle in which the new row indices appear.
- R2: The physical row index runs 0,1,…,63 on successive strobes and then wraps to 0. The first strobe after enabling starts physical row 0.
- R3: The rows-per-frame code selects the logical height: code 00 = 64, 01 = 48, 10 = 32, 11 = 16. The logical row index counts up with each strobe and returns to 0 after height−1, and also at every physical row 0. With code 01 the second logical frame ends after 16 rows.
- R4: The interrupt request rises in the cycle of the strobe that starts logical row H/4+1 or 3H/4+1, where H is the logical height (17 and 49 for H = 64). It stays high until an acknowledge is seen while it is high. A further interrupt row reached while it is pending does not produce a second request.
- R5: The DMA start pulses for one cycle with the strobe of every row that is not an interrupt row. For an interrupt row there is no pulse at the strobe. Instead, a pulse follows in the cycle after the acknowledge is accepted.
- R6: The polarity output flips at each strobe that starts physical row 0 and holds at every other time. After reset it is 0.
- R7: While enable is low: there are no strobes and no DMA starts; any pending interrupt is cleared; the physical row reads 63 and the logical row reads 0; the polarity holds its value.
- R8: After reset: strobe, interrupt and DMA start are 0, physical row is 63, logical row is 0 and polarity is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Display enable; low parks the scanner |
| rows_code_i | input | 2 | Logical frame height code (00=64, 01=48, 10=32, 11=16) |
| tick_div_i | input | DIV_W | Row period minus one, in clock cycles |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| row_strobe_o | output | 1 | One-cycle pulse at each row start |
| phys_row_o | output | ROW_W | Current physical row |
| log_row_o | output | ROW_W | Current logical row |
| irq_o | output | 1 | Interrupt request, held until acknowledged |
| dma_start_o | output | 1 | One-cycle row fetch start request |
| polarity_o | output | 1 | Drive polarity, flips each physical frame |

## Verification
A wrong divider count changes the spacing between strobes, so it shows up at the second strobe after enabling. A wrong logical counter shows on log_row_o at the first row where it should wrap. In 48-row mode that is row 48 of the physical frame. Because the interrupt rows are keyed to the logical index, the same fault also moves the interrupt. A stuck interrupt or acknowledge path shows within one cycle of the acknowledge, as a request that does not drop or a DMA start that does not come. A polarity fault can only be seen once per physical frame, at each return to row 0.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        HGT_FULL    = 2'b00,
        HGT_3QTR    = 2'b01,
        HGT_HALF    = 2'b10,
        HGT_QUARTER = 2'b11
    } height_code_e;

    // Logical frame height in rows for a given code and physical height.
    function automatic int unsigned logical_height(input logic [1:0] code,
                                                   input int unsigned phys_rows);
        case (height_code_e'(code))
            HGT_FULL:    return phys_rows;
            HGT_3QTR:    return (phys_rows * 3) / 4;
            HGT_HALF:    return phys_rows / 2;
            default:     return phys_rows / 4;
        endcase
    endfunction

    // First interrupt row: one past the quarter point.
    function automatic int unsigned irq_row_early(input int unsigned h);
        return (h / 4) + 1;
    endfunction

    // Second interrupt row: one past the three-quarter point.
    function automatic int unsigned irq_row_late(input int unsigned h);
        return 3 * (h / 4) + 1;
    endfunction

endpackage

// File: rtl/scan_row_divider.sv
module scan_row_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_q, st_d;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        wrap = enable_i && (st_q.cnt >= div_i);
        if (!enable_i || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign tick_o = wrap;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A row period restarts counting from zero after every tick.
    assert_tick_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (st_q.cnt == '0));

    // No tick is produced while disabled.
    assert_no_tick_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !tick_o);

endmodule

// File: rtl/scan_row_counter.sv
module scan_row_counter
    import scan_pkg::*;
#(
    parameter int PHYS_ROWS = 64,
    parameter int ROW_W     = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic [1:0]       height_i,
    output logic [ROW_W-1:0] phys_o,
    output logic [ROW_W-1:0] log_o,
    output logic [ROW_W-1:0] log_next_o,
    output logic             polarity_o,
    output logic             strobe_o
);

    localparam logic [ROW_W-1:0] LAST_PHYS = ROW_W'(PHYS_ROWS - 1);

    typedef struct packed {
        logic [ROW_W-1:0] phys;
        logic [ROW_W-1:0] lrow;
        logic             pol;
        logic             strobe;
    } row_state_t;

    row_state_t       st_q, st_d;
    int unsigned      height;
    logic [ROW_W-1:0] height_last;
    logic             frame_end;
    logic [ROW_W-1:0] phys_next;
    logic [ROW_W-1:0] log_next;

    always_comb begin
        height      = logical_height(height_i, PHYS_ROWS);
        height_last = ROW_W'(height - 1);
        frame_end   = (st_q.phys == LAST_PHYS);

        phys_next = frame_end ? '0 : st_q.phys + 1'b1;
        if (frame_end || (st_q.lrow >= height_last)) begin
            log_next = '0;
        end else begin
            log_next = st_q.lrow + 1'b1;
        end

        st_d = st_q;
        if (!enable_i) begin
            st_d.phys   = LAST_PHYS;
            st_d.lrow   = '0;
            st_d.strobe = 1'b0;
        end else begin
            st_d.strobe = tick_i;
            if (tick_i) begin
                st_d.phys = phys_next;
                st_d.lrow = log_next;
                st_d.pol  = st_q.pol ^ frame_end;
            end
        end
    end

    assign phys_o     = st_q.phys;
    assign log_o      = st_q.lrow;
    assign log_next_o = log_next;
    assign polarity_o = st_q.pol;
    assign strobe_o   = st_q.strobe;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phys   <= LAST_PHYS;
            st_q.lrow   <= '0;
            st_q.pol    <= 1'b0;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Wrapping past the last physical row starts physical and logical row 0.
    assert_frame_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && tick_i && st_q.phys == LAST_PHYS) |=> (st_q.phys == '0 && st_q.lrow == '0));

    // Logical rows restart with every physical frame, so they never lead.
    assert_log_le_phys_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lrow <= st_q.phys);

    // Polarity flips on the physical frame start.
    assert_pol_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && tick_i && st_q.phys == LAST_PHYS) |=> (st_q.pol != $past(st_q.pol)));

    // Polarity holds whenever no frame starts.
    assert_pol_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(enable_i && tick_i && st_q.phys == LAST_PHYS) |=> $stable(st_q.pol));

endmodule

// File: rtl/scan_irq_dma.sv
module scan_irq_dma
    import scan_pkg::*;
#(
    parameter int PHYS_ROWS = 64,
    parameter int ROW_W     = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             tick_i,
    input  logic [ROW_W-1:0] log_next_i,
    input  logic [1:0]       height_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic             dma_start_o
);

    typedef struct packed {
        logic irq;
        logic dma;
    } irq_state_t;

    irq_state_t       st_q, st_d;
    int unsigned      height;
    logic [ROW_W-1:0] row_early;
    logic [ROW_W-1:0] row_late;
    logic             irq_row;
    logic             ack_take;

    always_comb begin
        height    = logical_height(height_i, PHYS_ROWS);
        row_early = ROW_W'(irq_row_early(height));
        row_late  = ROW_W'(irq_row_late(height));
        irq_row   = enable_i && tick_i &&
                    ((log_next_i == row_early) || (log_next_i == row_late));
        ack_take  = ack_i && st_q.irq;

        st_d = st_q;
        if (!enable_i) begin
            st_d.irq = 1'b0;
            st_d.dma = 1'b0;
        end else begin
            st_d.irq = irq_row || (st_q.irq && !ack_i);
            st_d.dma = (tick_i && !irq_row) || ack_take;
        end
    end

    assign irq_o       = st_q.irq;
    assign dma_start_o = st_q.dma;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A pending request survives until acknowledged.
    assert_irq_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && st_q.irq && !ack_i) |=> st_q.irq);

    // An interrupt row does not fetch at its strobe.
    assert_dma_withheld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_row && !(ack_i && st_q.irq)) |=> !st_q.dma);

    // An accepted acknowledge releases the held fetch and drops the request.
    assert_ack_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && st_q.irq && ack_i && !tick_i) |=> (st_q.dma && !st_q.irq));

endmodule

// File: rtl/frame_scan_timer.sv
module frame_scan_timer #(
    parameter int PHYS_ROWS = 64,
    parameter int DIV_W     = 16,
    localparam int ROW_W    = $clog2(PHYS_ROWS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic [1:0]       rows_code_i,
    input  logic [DIV_W-1:0] tick_div_i,
    input  logic             irq_ack_i,
    output logic             row_strobe_o,
    output logic [ROW_W-1:0] phys_row_o,
    output logic [ROW_W-1:0] log_row_o,
    output logic             irq_o,
    output logic             dma_start_o,
    output logic             polarity_o
);

    logic             row_tick;
    logic [ROW_W-1:0] log_next;

    scan_row_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (enable_i),
        .div_i    (tick_div_i),
        .tick_o   (row_tick)
    );

    scan_row_counter #(
        .PHYS_ROWS (PHYS_ROWS),
        .ROW_W     (ROW_W)
    ) u_rows (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .tick_i     (row_tick),
        .height_i   (rows_code_i),
        .phys_o     (phys_row_o),
        .log_o      (log_row_o),
        .log_next_o (log_next),
        .polarity_o (polarity_o),
        .strobe_o   (row_strobe_o)
    );

    scan_irq_dma #(
        .PHYS_ROWS (PHYS_ROWS),
        .ROW_W     (ROW_W)
    ) u_irq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .enable_i    (enable_i),
        .tick_i      (row_tick),
        .log_next_i  (log_next),
        .height_i    (rows_code_i),
        .ack_i       (irq_ack_i),
        .irq_o       (irq_o),
        .dma_start_o (dma_start_o)
    );

    // Disabled display stays quiet at the ports.
    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (!row_strobe_o && !dma_start_o && !irq_o));

    // Every strobe is accompanied by either a fetch or a pending interrupt.
    assert_strobe_service_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        row_strobe_o |-> (dma_start_o || irq_o));

endmodule

// File: tb/sim_frame_scan_timer.sv
`timescale 1ns/1ps
module sim_frame_scan_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  code = 2'b00;
    logic [15:0] div = 16'd3;
    logic        ack = 1'b0;
    logic        strobe, irq, dma, pol;
    logic [5:0]  phys, lrow;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frame_scan_timer u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (en),
        .rows_code_i  (code),
        .tick_div_i   (div),
        .irq_ack_i    (ack),
        .row_strobe_o (strobe),
        .phys_row_o   (phys),
        .log_row_o    (lrow),
        .irq_o        (irq),
        .dma_start_o  (dma),
        .polarity_o   (pol)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (!strobe);
    endtask

    function automatic int height_of(input logic [1:0] c);
        case (c)
            2'b00:   return 64;
            2'b01:   return 48;
            2'b10:   return 32;
            default: return 16;
        endcase
    endfunction

    task automatic restart(input logic [1:0] c, input logic [15:0] d);
        @(negedge clk);
        en = 1'b0;
        ack = 1'b0;
        repeat (3) @(negedge clk);
        code = c;
        div = d;
        en = 1'b1;
    endtask

    task automatic t_reset();
        chk("R8 strobe", strobe, 0);
        chk("R8 irq", irq, 0);
        chk("R8 dma", dma, 0);
        chk("R8 phys", phys, 63);
        chk("R8 log", lrow, 0);
        chk("R8 pol", pol, 0);
    endtask

    task automatic t_period(input logic [15:0] d);
        int gap;
        restart(2'b00, d);
        wait_strobe();
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (gap == 1 && d != 0) chk("R1 strobe width", strobe, 0);
        end while (!strobe);
        chk("R1 row period", gap, int'(d) + 1);
    endtask

    // Runs rows with prompt acknowledges and checks every row against a model.
    task automatic t_frames(input logic [1:0] c, input int nrows);
        int h, e1, e2, elog, epol;
        logic pt;
        h = height_of(c);
        e1 = h / 4 + 1;
        e2 = 3 * (h / 4) + 1;
        restart(c, 16'd3);
        epol = pol;
        elog = 0;
        for (int r = 0; r < nrows; r++) begin
            wait_strobe();
            if (r % 64 == 0) begin
                elog = 0;
                epol = epol ^ 1;
            end
            chk("R2 phys row", phys, r % 64);
            chk("R3 logical row", lrow, elog);
            chk("R6 polarity", pol, epol);
            pt = (elog == e1) || (elog == e2);
            chk("R4 irq at strobe", irq, pt);
            chk("R5 dma at strobe", dma, !pt);
            if (pt) begin
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                chk("R4 irq cleared by ack", irq, 0);
                chk("R5 dma after ack", dma, 1);
            end
            elog = (elog == h - 1) ? 0 : elog + 1;
        end
    endtask

    // Withholds the acknowledge across several interrupt rows.
    task automatic t_no_ack();
        restart(2'b11, 16'd3);
        for (int r = 0; r < 40; r++) begin
            wait_strobe();
            chk("R4 irq pending", irq, (r >= 5) ? 1 : 0);
            chk("R5 dma unacked", dma, ((r % 16 == 5) || (r % 16 == 13)) ? 0 : 1);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R4 single ack clears", irq, 0);
        chk("R5 held dma released", dma, 1);
        @(negedge clk);
        chk("R5 dma one cycle", dma, 0);
        wait_strobe();
        chk("R4 no queued irq", irq, 0);
        chk("R3 logical after ack", lrow, 8);
    endtask

    task automatic t_disable();
        int seen;
        logic held;
        restart(2'b11, 16'd3);
        for (int r = 0; r < 7; r++) wait_strobe();
        chk("R4 irq pending before disable", irq, 1);
        held = pol;
        en = 1'b0;
        @(negedge clk);
        chk("R7 irq cleared", irq, 0);
        chk("R7 phys parked", phys, 63);
        chk("R7 log parked", lrow, 0);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (strobe || dma) seen++;
            if (pol != held) seen++;
        end
        chk("R7 quiet while disabled", seen, 0);
        en = 1'b1;
        wait_strobe();
        chk("R2 first row after enable", phys, 0);
        chk("R6 flip on re-enable", pol, held ^ 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period(16'd5);
        t_period(16'd0);
        t_period(16'd2);
        t_frames(2'b00, 130);
        t_frames(2'b01, 130);
        t_frames(2'b10, 70);
        t_frames(2'b11, 70);
        t_no_ack();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule